// File: doc/BRIEF.md
# Opcode-Selected PC Redirect Arbiter

This block sits at one pipeline stage of a core that hosts several custom-instruction units. Each unit may offer a 32-bit branch target with a valid bit in that stage. The block does not pick a unit by request priority. It compares the instruction word held in the stage with each unit's encoding pattern. A pattern is a 32-bit value plus a 32-bit care vector, and any bit whose care bit is zero is a don't-care. Only the unit whose pattern matches can steer the program counter.

When the matching unit's target is valid, the block forwards that target with a valid bit. In the same cycle it raises a flush request, so the unit never has to ask for the flush itself. The outputs are registered, which means there is no combinational path from anything the units read in the stage to the redirect output. An input from the memory stage reports that an older instruction has already committed a memory result. While it is high, no redirect is issued. Patterns and the unit count (1 to 8) are fixed when the block is elaborated.

Top module: `pc_redirect_arb`

## Requirements
- R1: One clock edge after the inputs are sampled, `match_o[k]` is 1 exactly when `stage_vld_i` was 1 and `((instr_i ^ VAL_k) & CARE_k) == 0`. Here VAL_k and CARE_k are bits `[32k+31:32k]` of `MASK_VAL` and `MASK_CARE`. By default, unit k matches major opcode `0001011` (bits 6:0) with bits 14:12 equal to k.
- R2: When unit k matches and `tgt_vld_i[k]` is 1 (and `mem_done_i` is 0), `pc_vld_o` is 1 and `pc_o` equals `tgt_i[32k+31:32k]` one edge later.
- R3: When the matching unit's `tgt_vld_i` bit is 0, `pc_vld_o` is 0 and `pc_o` is 0. The targets and valids of units that do not match have no effect on the outputs.
- R4: When no pattern matches, or `stage_vld_i` is 0, `pc_vld_o`, `flush_o` and `pc_o` are all 0.
- R5: `flush_o` is 1 exactly in the cycles where `pc_vld_o` is 1.
- R6: While `mem_done_i` is 1, no redirect and no flush are issued. `match_o` still reports the matches.
- R7: If several patterns match, the lowest-index unit supplies target and valid. With `CHECK_OVERLAP=1`, an assertion flags more than one match.
- R8: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word resident in the stage |
| stage_vld_i | input | 1 | Stage holds a live instruction |
| tgt_i | input | 32*NUM_UNITS | Per-unit redirect target, unit k at bits [32k+31:32k] |
| tgt_vld_i | input | NUM_UNITS | Per-unit redirect valid |
| mem_done_i | input | 1 | An older instruction has committed a memory result |
| pc_o | output | 32 | Selected redirect target, 0 when not valid |
| pc_vld_o | output | 1 | Redirect taken |
| flush_o | output | 1 | Flush request for the stage |
| match_o | output | NUM_UNITS | Per-unit pattern match |

## Verification
All four outputs come from one register rank, so every result is due exactly one rising edge after the inputs that caused it. The bench drives each input set just after a rising edge. It then waits for the next rising edge and samples 1 ns later, so it always reads the result of the set it has just applied and never that of the following one. The expected values come from the pattern rules in R1 to R7. A second instance with overlapping patterns, sharing the same inputs, exercises the lowest-index rule.

// File: rtl/pc_redir_pkg.sv
package pc_redir_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  function automatic logic pattern_hit(word_t instr, word_t val, word_t care);
    return ((instr ^ val) & care) == '0;
  endfunction
endpackage

// File: rtl/pc_redir_match.sv
module pc_redir_match
  import pc_redir_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4,
  parameter logic [NUM_UNITS*WORD_W-1:0] MASK_VAL  = '0,
  parameter logic [NUM_UNITS*WORD_W-1:0] MASK_CARE = '0
) (
  input  word_t                instr_i,
  input  logic                 en_i,
  output logic [NUM_UNITS-1:0] hit_o
);
  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    localparam word_t VAL_K  = MASK_VAL[k*WORD_W +: WORD_W];
    localparam word_t CARE_K = MASK_CARE[k*WORD_W +: WORD_W];
    assign hit_o[k] = en_i & pattern_hit(instr_i, VAL_K, CARE_K);
  end
endmodule

// File: rtl/pc_redir_pick.sv
module pc_redir_pick
  import pc_redir_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic [NUM_UNITS-1:0]        hit_i,
  input  logic [NUM_UNITS*WORD_W-1:0] tgt_i,
  input  logic [NUM_UNITS-1:0]        tgt_vld_i,
  output logic                        sel_vld_o,
  output word_t                       sel_tgt_o
);
  // scan high to low so the lowest index is written last and wins
  always_comb begin
    sel_vld_o = 1'b0;
    sel_tgt_o = '0;
    for (int k = NUM_UNITS - 1; k >= 0; k--) begin
      if (hit_i[k]) begin
        sel_vld_o = tgt_vld_i[k];
        sel_tgt_o = tgt_vld_i[k] ? tgt_i[k*WORD_W +: WORD_W] : '0;
      end
    end
  end
endmodule

// File: rtl/pc_redirect_arb.sv
module pc_redirect_arb
  import pc_redir_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4,
  parameter logic [NUM_UNITS*WORD_W-1:0] MASK_VAL =
    {32'h0000_300B, 32'h0000_200B, 32'h0000_100B, 32'h0000_000B},
  parameter logic [NUM_UNITS*WORD_W-1:0] MASK_CARE =
    {4{32'h0000_707F}},
  parameter bit CHECK_OVERLAP = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [31:0]                 instr_i,
  input  logic                        stage_vld_i,
  input  logic [NUM_UNITS*WORD_W-1:0] tgt_i,
  input  logic [NUM_UNITS-1:0]        tgt_vld_i,
  input  logic                        mem_done_i,
  output logic [31:0]                 pc_o,
  output logic                        pc_vld_o,
  output logic                        flush_o,
  output logic [NUM_UNITS-1:0]        match_o
);
  logic [NUM_UNITS-1:0] hit;
  logic                 sel_vld;
  word_t                sel_tgt;
  logic                 take;

  pc_redir_match #(
    .NUM_UNITS(NUM_UNITS), .MASK_VAL(MASK_VAL), .MASK_CARE(MASK_CARE)
  ) u_match (
    .instr_i(instr_i), .en_i(stage_vld_i), .hit_o(hit)
  );

  pc_redir_pick #(.NUM_UNITS(NUM_UNITS)) u_pick (
    .hit_i(hit), .tgt_i(tgt_i), .tgt_vld_i(tgt_vld_i),
    .sel_vld_o(sel_vld), .sel_tgt_o(sel_tgt)
  );

  assign take = sel_vld & ~mem_done_i;

  // registered outputs: no same-cycle path from stage reads to redirect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o     <= '0;
      pc_vld_o <= 1'b0;
      flush_o  <= 1'b0;
      match_o  <= '0;
    end else begin
      pc_o     <= take ? sel_tgt : '0;
      pc_vld_o <= take;
      flush_o  <= take;
      match_o  <= hit;
    end
  end

  assert_flush_tracks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o == pc_vld_o);
  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_vld_o |-> pc_o == '0);
  assert_needs_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_vld_o |-> match_o != '0);
  assert_mem_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_done_i |=> !pc_vld_o);
  assert_stage_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_vld_i |=> match_o == '0);

  if (CHECK_OVERLAP) begin : g_overlap
    assert_single_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(match_o) <= 1);
  end
endmodule

// File: tb/pc_redirect_arb_tb.sv
module pc_redirect_arb_tb;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] instr;
  logic stage_vld, mem_done;
  logic [N*32-1:0] tgt;
  logic [N-1:0] tgt_vld;
  logic [31:0] pc_a, pc_b;
  logic vld_a, vld_b, fl_a, fl_b;
  logic [N-1:0] m_a;
  logic [1:0] m_b;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  pc_redirect_arb u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .stage_vld_i(stage_vld),
    .tgt_i(tgt), .tgt_vld_i(tgt_vld), .mem_done_i(mem_done),
    .pc_o(pc_a), .pc_vld_o(vld_a), .flush_o(fl_a), .match_o(m_a));

  // overlapping patterns: unit0 any funct3, unit1 funct3=1
  pc_redirect_arb #(
    .NUM_UNITS(2),
    .MASK_VAL({32'h0000_100B, 32'h0000_000B}),
    .MASK_CARE({32'h0000_707F, 32'h0000_007F}),
    .CHECK_OVERLAP(1'b0)
  ) u_dut_ovl (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .stage_vld_i(stage_vld),
    .tgt_i(tgt[63:0]), .tgt_vld_i(tgt_vld[1:0]), .mem_done_i(mem_done),
    .pc_o(pc_b), .pc_vld_o(vld_b), .flush_o(fl_b), .match_o(m_b));

  function automatic logic [N-1:0] exp_match_a(logic [31:0] i, logic sv);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++)
      r[k] = sv && i[6:0] == 7'h0B && i[14:12] == 3'(k);
    return r;
  endfunction

  function automatic logic [1:0] exp_match_b(logic [31:0] i, logic sv);
    return {sv && i[6:0] == 7'h0B && i[14:12] == 3'd1, sv && i[6:0] == 7'h0B};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply_check(logic [31:0] i, logic sv, logic [N*32-1:0] t,
                             logic [N-1:0] tv, logic md);
    logic [N-1:0] ea; logic [1:0] eb;
    logic va, vb; logic [31:0] pa, pb;
    instr = i; stage_vld = sv; tgt = t; tgt_vld = tv; mem_done = md;
    ea = exp_match_a(i, sv); eb = exp_match_b(i, sv);
    va = 1'b0; pa = '0; vb = 1'b0; pb = '0;
    for (int k = N - 1; k >= 0; k--)
      if (ea[k]) begin va = tv[k] && !md; pa = va ? t[k*32 +: 32] : '0; end
    for (int k = 1; k >= 0; k--)
      if (eb[k]) begin vb = tv[k] && !md; pb = vb ? t[k*32 +: 32] : '0; end
    @(posedge clk); #1;
    chk("R1 match", 64'(m_a), 64'(ea));
    chk("R2/R3/R4/R6 valid", 64'(vld_a), 64'(va));
    chk("R2/R3/R4 target", 64'(pc_a), 64'(pa));
    chk("R5 flush", 64'(fl_a), 64'(va));
    chk("R7 ovl match", 64'(m_b), 64'(eb));
    chk("R7 ovl valid", 64'(vld_b), 64'(vb));
    chk("R7 ovl target", 64'(pc_b), 64'(pb));
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N*32-1:0] t;
    void'($urandom(32'd7));
    instr = 32'h0000_000B; stage_vld = 1; tgt = '1; tgt_vld = '1; mem_done = 0;
    #25;
    chk("R8 reset pc", 64'(pc_a), 0);
    chk("R8 reset vld", 64'(vld_a), 0);
    chk("R8 reset flush", 64'(fl_a), 0);
    chk("R8 reset match", 64'(m_a), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    for (int k = 0; k < N; k++) t[k*32 +: 32] = 32'h1000_0000 + 32'(k) * 32'h111;
    // R2 each unit selected by its funct3
    for (int k = 0; k < N; k++)
      apply_check(32'hABC0_000B | (32'(k) << 12), 1, t, '1, 0);
    // R3 matching unit not valid, others valid
    apply_check(32'h0000_200B, 1, t, 4'b1011, 0);
    // R4 no match / stage idle
    apply_check(32'h0000_2033, 1, t, '1, 0);
    apply_check(32'h0000_100B, 0, t, '1, 0);
    // R6 memory committed earlier
    apply_check(32'h0000_300B, 1, t, '1, 1);
    // R7 overlap: funct3=1 hits both units of second instance
    apply_check(32'h0000_100B, 1, t, 4'b0010, 0);
    apply_check(32'h0000_100B, 1, t, 4'b0011, 0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] i;
      i = $urandom;
      if ($urandom_range(3) != 0) i[6:0] = 7'h0B;
      for (int k = 0; k < N; k++) t[k*32 +: 32] = $urandom;
      apply_check(i, $urandom_range(4) != 0, t, N'($urandom),
                  $urandom_range(5) == 0);
    end
    // R8 asynchronous reset mid-run
    #5; rst_ni = 1'b0; #1;
    chk("R8 async reset vld", 64'(vld_a), 0);
    chk("R8 async reset match", 64'(m_a), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule